// File: doc/BRIEF.md
# Single-Mode DMA Channel Transfer Sequencer

This block carries out one transfer request on one channel of a four-channel DMA controller. The request supplies the channel's programmed mode, the controller-off flag, the channel mask bits, an 8-bit page value, the channel's current and base address and count, and the number of elements the requesting device wants to move. The sequencer checks whether the request may run, moves the elements one at a time, and then reports the channel's new address and count. When the count runs out, it also raises the terminal-count status pulses and either reloads the channel or masks it.

For each element the sequencer builds a 24-bit physical address from the page and the current address, and holds a memory request until the memory side acknowledges it. In verify mode no memory request is made and one element is counted per cycle. Byte channels and word channels differ only in how the 16-bit address sits inside the physical address. The caller keeps the register file. It applies the update pulse and the status and mask pulses to that file, and uses the done pulse with its element count as the reply to the requesting device.

Top module: `dma_xfer_engine`

## Requirements
- R1: When `ctl_off` is 1 or `mask_bits[chan]` is 1, the request makes no memory request, gives no update pulse, and ends with `done` and a `done_count` of 0.
- R2: Only operating mode 1 (single) in `mode_hi[5:4]` moves data. Modes 0, 2 and 3 are refused in the same way as R1.
- R3: `mode_hi[1:0]` selects the transfer type. 0 is verify: elements are counted and no memory request is made. 1 is write: `mem_we`=1. 2 is read: `mem_we`=0. 3 is refused in the same way as R1.
- R4: On a byte channel (`word_chan`=0), `mem_addr` = {page, addr}. On a word channel, `mem_addr` = {page, (addr shifted left by one)[15:0]}.
- R5: When `mode_hi[3]` is 0, the address rises by one per element. When it is 1, the address falls by one. The address wraps modulo 2^16 and the page is never changed.
- R6: The element count is min(`cur_cnt`, `req_len`). `done_count` reports that count, and the count reported on the update pulse is `cur_cnt` minus that count.
- R7: When the count reaches zero, the update cycle pulses `stat_set` bit `chan` and `stat_clr` bit `chan`+4, and no other bits. Otherwise both are 0.
- R8: At zero count with autoinit (`mode_hi[2]`=1), `upd_addr`/`upd_cnt` carry the base address and count. Without autoinit, they carry the stepped address and 0, and `mask_set` bit `chan` pulses.
- R9: `mem_req` holds `mem_addr` and `mem_we` steady until `mem_ack` is seen at a clock edge. Each acknowledge moves exactly one element.
- R10: A request whose element count is 0 gives no update pulse and reports `done_count` 0.
- R11: After reset, `busy`, `mem_req`, `upd_valid` and `done` are 0. `busy` stays 1 from the cycle after `start` until the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins a request; inputs are captured with it |
| chan | input | 2 | Channel number within the controller |
| word_chan | input | 1 | 1 for a 16-bit channel |
| mode_hi | input | 6 | Mode byte bits 7:2: {opmode[1:0], down, autoinit, type[1:0]} |
| ctl_off | input | 1 | Controller-disable bit of the command byte |
| mask_bits | input | 4 | Channel mask bits |
| page | input | 8 | Page value for the channel |
| cur_addr | input | 16 | Current address |
| cur_cnt | input | 16 | Current count |
| base_addr | input | 16 | Base address for reload |
| base_cnt | input | 16 | Base count for reload |
| req_len | input | 16 | Elements offered by the requesting device |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write to memory |
| mem_addr | output | 24 | Physical address |
| mem_ack | input | 1 | Memory access accepted |
| busy | output | 1 | Request in progress |
| upd_valid | output | 1 | Channel update pulse |
| upd_addr | output | 16 | New current address |
| upd_cnt | output | 16 | New current count |
| stat_set | output | 8 | Status bits to set |
| stat_clr | output | 8 | Status bits to clear |
| mask_set | output | 4 | Mask bits to set |
| done | output | 1 | Request finished pulse |
| done_count | output | 16 | Elements moved |

## Verification
The assertions assume three things about the inputs. `start` arrives only while `busy` is 0. The request inputs are captured at `start` and may change afterwards. `mem_ack` has meaning only while `mem_req` is high. The stability property also assumes the memory side never acknowledges ahead of a request. The bench drives `start` only between requests and changes the request inputs only around `start`. Its memory model raises `mem_ack` only in reply to a pending `mem_req`, after 0 to 2 random wait cycles, and drops it in the following cycle. Counts are kept small so that each random request finishes in a few dozen cycles.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;

  typedef enum logic [2:0] {
    S_IDLE, S_CHECK, S_XFER, S_UPDATE, S_DONE
  } eng_state_t;

  typedef enum logic [1:0] {
    TY_VERIFY = 2'd0,
    TY_WRITE  = 2'd1,
    TY_READ   = 2'd2,
    TY_BAD    = 2'd3
  } xfer_ty_t;

  // operating-mode code that performs transfers
  localparam logic [1:0] OPM_SINGLE = 2'd1;

  // bit positions inside mode_hi (mode byte bits 7:2)
  localparam int MF_OPM_HI = 5;
  localparam int MF_OPM_LO = 4;
  localparam int MF_DOWN   = 3;
  localparam int MF_AUTO   = 2;

endpackage

// File: rtl/dma_mode_decode.sv
module dma_mode_decode
  import dma_xfer_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int CH_W = $clog2(NCH)
)(
  input  logic [5:0]      mode_hi,
  input  logic            ctl_off,
  input  logic [NCH-1:0]  mask_bits,
  input  logic [CH_W-1:0] chan,
  output xfer_ty_t        ty,
  output logic            down,
  output logic            autoinit,
  output logic            accept
);
  logic [1:0] opm;
  logic       blocked;

  assign opm      = mode_hi[MF_OPM_HI:MF_OPM_LO];
  assign down     = mode_hi[MF_DOWN];
  assign autoinit = mode_hi[MF_AUTO];
  assign ty       = xfer_ty_t'(mode_hi[1:0]);
  assign blocked  = ctl_off | mask_bits[chan];
  assign accept   = !blocked && (opm == OPM_SINGLE) && (ty != TY_BAD);
endmodule

// File: rtl/dma_addr_form.sv
module dma_addr_form #(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int PHYS_W = ADDR_W + PAGE_W
)(
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] addr,
  input  logic              word_chan,
  output logic [PHYS_W-1:0] phys
);
  function automatic logic [PHYS_W-1:0] form_phys(
    input logic [PAGE_W-1:0] pg,
    input logic [ADDR_W-1:0] a,
    input logic              wide
  );
    logic [ADDR_W-1:0] off;
    off = wide ? {a[ADDR_W-2:0], 1'b0} : a;
    return {pg, off};
  endfunction

  assign phys = form_phys(page, addr, word_chan);
endmodule

// File: rtl/dma_tc_unit.sv
module dma_tc_unit #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int NCH    = 4,
  localparam int CH_W  = $clog2(NCH)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic              autoinit,
  input  logic [CH_W-1:0]   chan,
  input  logic [ADDR_W-1:0] fin_addr,
  input  logic [CNT_W-1:0]  fin_cnt,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  base_cnt,
  output logic              upd_valid,
  output logic [ADDR_W-1:0] upd_addr,
  output logic [CNT_W-1:0]  upd_cnt,
  output logic [2*NCH-1:0]  stat_set,
  output logic [2*NCH-1:0]  stat_clr,
  output logic [NCH-1:0]    mask_set
);
  logic tc_hit;
  logic reload;

  assign tc_hit    = fire && (fin_cnt == '0);
  assign reload    = tc_hit && autoinit;
  assign upd_valid = fire;
  assign upd_addr  = reload ? base_addr : fin_addr;
  assign upd_cnt   = reload ? base_cnt  : fin_cnt;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit_i;
    assign hit_i             = tc_hit && (chan == CH_W'(i));
    assign stat_set[i]       = hit_i;
    assign stat_set[i+NCH]   = 1'b0;
    assign stat_clr[i]       = 1'b0;
    assign stat_clr[i+NCH]   = hit_i;
    assign mask_set[i]       = hit_i && !autoinit;
  end

  // status pulses touch at most one channel
  assert_one_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(stat_set) <= 1) && ($countones(stat_clr) == $countones(stat_set)));
  // mask only raised at terminal count without reload
  assert_mask_on_tc_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_set != '0) |-> (upd_valid && !autoinit && upd_cnt == '0));
  assert_status_only_on_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_set != '0) |-> upd_valid);
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
  import dma_xfer_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int PAGE_W = 8,
  parameter int NCH    = 4,
  localparam int CH_W   = $clog2(NCH),
  localparam int PHYS_W = ADDR_W + PAGE_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CH_W-1:0]   chan,
  input  logic              word_chan,
  input  logic [5:0]        mode_hi,
  input  logic              ctl_off,
  input  logic [NCH-1:0]    mask_bits,
  input  logic [PAGE_W-1:0] page,
  input  logic [ADDR_W-1:0] cur_addr,
  input  logic [CNT_W-1:0]  cur_cnt,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  base_cnt,
  input  logic [CNT_W-1:0]  req_len,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PHYS_W-1:0] mem_addr,
  input  logic              mem_ack,
  output logic              busy,
  output logic              upd_valid,
  output logic [ADDR_W-1:0] upd_addr,
  output logic [CNT_W-1:0]  upd_cnt,
  output logic [2*NCH-1:0]  stat_set,
  output logic [2*NCH-1:0]  stat_clr,
  output logic [NCH-1:0]    mask_set,
  output logic              done,
  output logic [CNT_W-1:0]  done_count
);
  eng_state_t        st;
  logic [5:0]        mode_q;
  logic              off_q;
  logic [NCH-1:0]    mask_q;
  logic [CH_W-1:0]   chan_q;
  logic              word_q;
  logic [PAGE_W-1:0] page_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] base_a_q;
  logic [CNT_W-1:0]  base_c_q;
  logic [CNT_W-1:0]  left_q;
  logic [CNT_W-1:0]  moved_q;

  xfer_ty_t ty;
  logic     down, autoinit, accept;
  logic     step_en;   // one element retired this cycle
  logic     last_el;   // the element retiring is the final one

  function automatic logic [ADDR_W-1:0] step_addr(
    input logic [ADDR_W-1:0] a, input logic dn);
    return dn ? a - ADDR_W'(1) : a + ADDR_W'(1);
  endfunction

  function automatic logic [CNT_W-1:0] lesser(
    input logic [CNT_W-1:0] x, input logic [CNT_W-1:0] y);
    return (x < y) ? x : y;
  endfunction

  dma_mode_decode #(.NCH(NCH)) u_dec (
    .mode_hi(mode_q), .ctl_off(off_q), .mask_bits(mask_q), .chan(chan_q),
    .ty(ty), .down(down), .autoinit(autoinit), .accept(accept)
  );

  dma_addr_form #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_addr (
    .page(page_q), .addr(addr_q), .word_chan(word_q), .phys(mem_addr)
  );

  dma_tc_unit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NCH(NCH)) u_tc (
    .clk(clk), .rst_n(rst_n), .fire(st == S_UPDATE), .autoinit(autoinit),
    .chan(chan_q), .fin_addr(addr_q), .fin_cnt(cnt_q),
    .base_addr(base_a_q), .base_cnt(base_c_q),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_cnt(upd_cnt),
    .stat_set(stat_set), .stat_clr(stat_clr), .mask_set(mask_set)
  );

  assign mem_req    = (st == S_XFER) && (ty != TY_VERIFY);
  assign mem_we     = (ty == TY_WRITE);
  assign step_en    = (st == S_XFER) && ((ty == TY_VERIFY) || mem_ack);
  assign last_el    = step_en && (left_q == CNT_W'(1));
  assign busy       = (st != S_IDLE);
  assign done       = (st == S_DONE);
  assign done_count = moved_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      mode_q   <= '0;
      off_q    <= 1'b0;
      mask_q   <= '0;
      chan_q   <= '0;
      word_q   <= 1'b0;
      page_q   <= '0;
      addr_q   <= '0;
      cnt_q    <= '0;
      base_a_q <= '0;
      base_c_q <= '0;
      left_q   <= '0;
      moved_q  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (start) begin
          mode_q   <= mode_hi;
          off_q    <= ctl_off;
          mask_q   <= mask_bits;
          chan_q   <= chan;
          word_q   <= word_chan;
          page_q   <= page;
          addr_q   <= cur_addr;
          cnt_q    <= cur_cnt;
          base_a_q <= base_addr;
          base_c_q <= base_cnt;
          left_q   <= lesser(cur_cnt, req_len);
          moved_q  <= '0;
          st       <= S_CHECK;
        end
        S_CHECK: st <= (accept && left_q != '0) ? S_XFER : S_DONE;
        S_XFER: if (step_en) begin
          addr_q  <= step_addr(addr_q, down);
          cnt_q   <= cnt_q - CNT_W'(1);
          left_q  <= left_q - CNT_W'(1);
          moved_q <= moved_q + CNT_W'(1);
          if (last_el) st <= S_UPDATE;
        end
        S_UPDATE: st <= S_DONE;
        S_DONE:   st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
    end
  end

  // a blocked or refused request never reaches the transfer state
  assert_refused_skips_xfer_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CHECK && !accept) |=> (st == S_DONE && moved_q == '0));
  assert_single_mode_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mode_q[MF_OPM_HI:MF_OPM_LO] == OPM_SINGLE));
  assert_type_matches_access_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mode_q[1:0] != 2'd0 && mode_q[1:0] != 2'd3 && mem_we == (mode_q[1:0] == 2'd1)));
  assert_req_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_one_element_per_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (moved_q == $past(moved_q) + CNT_W'(1)));
  assert_no_empty_update_R10: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (moved_q != '0));
  assert_done_then_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);
endmodule

// File: tb/dma_xfer_engine_test.sv
module dma_xfer_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  chan = '0;
  logic        word_chan = 1'b0;
  logic [5:0]  mode_hi = '0;
  logic        ctl_off = 1'b0;
  logic [3:0]  mask_bits = '0;
  logic [7:0]  page = '0;
  logic [15:0] cur_addr = '0, cur_cnt = '0, base_addr = '0, base_cnt = '0, req_len = '0;
  logic        mem_ack = 1'b0;
  logic        mem_req, mem_we, busy, upd_valid, done;
  logic [23:0] mem_addr;
  logic [15:0] upd_addr, upd_cnt, done_count;
  logic [7:0]  stat_set, stat_clr;
  logic [3:0]  mask_set;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  dma_xfer_engine uut (
    .clk(clk), .rst_n(rst_n), .start(start), .chan(chan), .word_chan(word_chan),
    .mode_hi(mode_hi), .ctl_off(ctl_off), .mask_bits(mask_bits), .page(page),
    .cur_addr(cur_addr), .cur_cnt(cur_cnt), .base_addr(base_addr), .base_cnt(base_cnt),
    .req_len(req_len), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .busy(busy), .upd_valid(upd_valid), .upd_addr(upd_addr),
    .upd_cnt(upd_cnt), .stat_set(stat_set), .stat_clr(stat_clr), .mask_set(mask_set),
    .done(done), .done_count(done_count)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] ref_phys(input logic [7:0] pg, input logic [15:0] a, input logic w);
    logic [16:0] dbl;
    dbl = {a, 1'b0};
    return w ? {pg, dbl[15:0]} : {pg, a};
  endfunction

  function automatic logic [15:0] ref_addr_k(input logic [15:0] a, input logic dn, input int k);
    return dn ? 16'(a - 16'(k)) : 16'(a + 16'(k));
  endfunction

  task automatic go(input logic [1:0] ch, input logic w, input logic [1:0] opm,
                    input logic dn, input logic au, input logic [1:0] ty,
                    input logic off, input logic [3:0] msk, input logic [7:0] pg,
                    input logic [15:0] ca, input logic [15:0] cc,
                    input logic [15:0] ba, input logic [15:0] bc, input logic [15:0] len);
    logic ok;
    int n, k, wt, cyc;
    logic pick, saw_upd, saw_done, saw_busy;
    logic [15:0] ua, uc;
    logic [7:0] ss, sc;
    logic [3:0] ms;
    logic [15:0] fin;
    ok = !off && !msk[ch] && opm == 2'd1 && ty != 2'd3;
    n  = ok ? int'((cc < len) ? cc : len) : 0;
    @(negedge clk);
    chan = ch; word_chan = w; mode_hi = {opm, dn, au, ty}; ctl_off = off;
    mask_bits = msk; page = pg; cur_addr = ca; cur_cnt = cc; base_addr = ba;
    base_cnt = bc; req_len = len; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    k = 0; wt = 0; pick = 1'b1; saw_upd = 0; saw_done = 0; saw_busy = busy;
    ua = '0; uc = '0; ss = '0; sc = '0; ms = '0;
    for (cyc = 0; cyc < 400 && !saw_done; cyc++) begin
      if (mem_req) begin
        if (pick) begin wt = int'($urandom % 3); pick = 1'b0; end
        if (wt == 0) begin
          chk(mem_addr == ref_phys(pg, ref_addr_k(ca, dn, k), w), "R4/R5 address",
              32'(mem_addr), 32'(ref_phys(pg, ref_addr_k(ca, dn, k), w)));
          chk(mem_we == (ty == 2'd1), "R3 direction", 32'(mem_we), 32'(ty == 2'd1));
          k++; mem_ack = 1'b1; pick = 1'b1;
        end else begin
          wt--; mem_ack = 1'b0;
        end
      end else mem_ack = 1'b0;
      if (upd_valid) begin
        saw_upd = 1; ua = upd_addr; uc = upd_cnt; ss = stat_set; sc = stat_clr; ms = mask_set;
      end
      if (done) begin
        saw_done = 1;
        chk(done_count == 16'(n), "R6 done_count", 32'(done_count), 32'(n));
      end
      if (!saw_done) @(negedge clk);
    end
    mem_ack = 1'b0;
    chk(saw_done, "R11 request finished", 32'(saw_done), 1);
    chk(saw_busy, "R11 busy after start", 32'(saw_busy), 1);
    chk(k == ((ty == 2'd0) ? 0 : n), "R1/R2/R3 access count", 32'(k), 32'((ty == 2'd0) ? 0 : n));
    chk(saw_upd == (n > 0), "R10 update present", 32'(saw_upd), 32'(n > 0));
    if (n > 0) begin
      fin = 16'(cc - 16'(n));
      if (fin == 0 && au) begin
        chk(ua == ba && uc == bc, "R8 reload", {ua, uc}, {ba, bc});
      end else begin
        chk(ua == ref_addr_k(ca, dn, n), "R5 final address", 32'(ua), 32'(ref_addr_k(ca, dn, n)));
        chk(uc == fin, "R6 final count", 32'(uc), 32'(fin));
      end
      chk(ss == ((fin == 0) ? 8'(1 << ch) : 8'h00), "R7 status set", 32'(ss), 32'((fin == 0) ? 8'(1 << ch) : 8'h00));
      chk(sc == ((fin == 0) ? 8'(1 << (ch + 4)) : 8'h00), "R7 status clear", 32'(sc), 32'((fin == 0) ? 8'(1 << (ch + 4)) : 8'h00));
      chk(ms == ((fin == 0 && !au) ? 4'(1 << ch) : 4'h0), "R8 mask set", 32'(ms), 32'((fin == 0 && !au) ? 4'(1 << ch) : 4'h0));
    end
    @(negedge clk);
    chk(!busy, "R11 idle after done", 32'(busy), 0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !upd_valid && !done, "R11 reset state",
        {busy, mem_req, upd_valid, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    go(2'd1, 0, 2'd1, 0, 0, 2'd1, 0, 4'h0, 8'h12, 16'h3000, 16'd5, 16'h0, 16'd0, 16'd10); // R7 R8 mask
    go(2'd2, 0, 2'd1, 1, 1, 2'd2, 0, 4'h0, 8'h05, 16'h0001, 16'd3, 16'h4440, 16'd9, 16'd3); // R5 wrap down, R8 reload
    go(2'd3, 1, 2'd1, 0, 0, 2'd0, 0, 4'h0, 8'h3C, 16'h1000, 16'd8, 16'h0, 16'd0, 16'd4); // R3 verify
    go(2'd1, 1, 2'd1, 0, 0, 2'd1, 0, 4'h0, 8'hA0, 16'h8FFF, 16'd2, 16'h0, 16'd0, 16'd2); // R4 word truncation
    go(2'd0, 0, 2'd1, 0, 0, 2'd2, 0, 4'h0, 8'h01, 16'hFFFE, 16'd4, 16'h0, 16'd0, 16'd9); // R5 wrap up
    go(2'd1, 0, 2'd1, 0, 0, 2'd1, 1, 4'h0, 8'h01, 16'h0100, 16'd4, 16'h0, 16'd0, 16'd4); // R1 disabled
    go(2'd2, 0, 2'd1, 0, 0, 2'd1, 0, 4'h4, 8'h01, 16'h0100, 16'd4, 16'h0, 16'd0, 16'd4); // R1 masked
    go(2'd2, 0, 2'd2, 0, 0, 2'd1, 0, 4'h0, 8'h01, 16'h0100, 16'd4, 16'h0, 16'd0, 16'd4); // R2 block
    go(2'd2, 0, 2'd3, 0, 0, 2'd1, 0, 4'h0, 8'h01, 16'h0100, 16'd4, 16'h0, 16'd0, 16'd4); // R2 cascade
    go(2'd2, 0, 2'd0, 0, 0, 2'd2, 0, 4'h0, 8'h01, 16'h0100, 16'd4, 16'h0, 16'd0, 16'd4); // R2 demand
    go(2'd3, 0, 2'd1, 0, 0, 2'd3, 0, 4'h0, 8'h01, 16'h0100, 16'd4, 16'h0, 16'd0, 16'd4); // R3 type 3
    go(2'd3, 0, 2'd1, 0, 0, 2'd1, 0, 4'h0, 8'h01, 16'h0100, 16'd4, 16'h0, 16'd0, 16'd0); // R10 len 0
    go(2'd3, 0, 2'd1, 0, 1, 2'd1, 0, 4'h0, 8'h01, 16'h0100, 16'd0, 16'h0, 16'd0, 16'd6); // R10 count 0
    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [1:0] opm;
      opm = ($urandom % 5 == 0) ? 2'($urandom) : 2'd1;
      go(2'($urandom), 1'($urandom), opm, 1'($urandom), 1'($urandom), 2'($urandom),
         ($urandom % 8 == 0), (($urandom % 6 == 0) ? 4'($urandom) : 4'h0), 8'($urandom),
         16'($urandom), 16'($urandom % 12), 16'($urandom), 16'($urandom % 12), 16'($urandom % 14));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule